// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the processor-facing control and status front end of one UART channel. It decodes single-cycle accesses within a 64-byte register window, which the surrounding bus fabric selects. It holds two mode registers behind an auto-advancing pointer, composes a status byte from its own transmit state, the receiver's level inputs and sticky error flags, and keeps an interrupt mask. A byte written to the transmit buffer offset waits in a one-entry holding register until a serializer takes it over a valid/ready handshake.

Writes to the command offset carry three independent fields: a miscellaneous action, a transmitter enable control and a receiver enable control. All three act in the same write. The block drives the receiver enable, a one-cycle receiver flush pulse and a line-break request to the receive and transmit shifters. It raises one level-sensitive interrupt. Baud generation, the shifters and the receive data path sit outside.

Top module: `uart_regctl`

## Requirements
- R1: After reset the status byte reads 0x08 (only transmitter-empty set), the interrupt status and mask read 0x00, both mode registers read 0x00, the pointer selects mode register 1, and tx_valid_o, rx_enable_o, rx_flush_o, tx_break_o and irq_o are low.
- R2: Any read or write at offset 0x00 reaches mode register 1 while the pointer is at 1, and moves the pointer to 2. The pointer stays at 2 until a command with misc field (bits [6:4]) equal to 1 returns it to 1.
- R3: Mapped offsets: 0x00 mode (read/write), 0x04 status (read), 0x08 command (write), 0x0C transmit buffer (write), 0x10 interrupt mask (read/write), 0x14 interrupt status (read). Reads of any other offset, and reads of 0x08 or 0x0C, return 0x00.
- R4: Writes to 0x04, 0x14 or an unmapped offset change no register or output.
- R5: A write at 0x0C stores the byte and clears status bit 3 (transmitter empty). While the transmitter is enabled and not empty, tx_valid_o is high and tx_data_o holds the byte steady. The cycle after tx_ready_i is seen with tx_valid_o, bit 3 is set again.
- R6: Status bit 0 follows rx_avail_i, bit 1 follows rx_full_i, and bit 2 (transmitter ready) is high exactly when the transmitter is enabled and empty.
- R7: Command bits [3:2] control the transmitter and bits [1:0] the receiver (rx_enable_o). In each field 1 enables, 2 disables, and 0 and 3 leave the enable unchanged.
- R8: Misc field 3 empties the holding buffer and disables the transmitter. Misc field 2 disables the receiver and pulses rx_flush_o for one cycle. An enable in the same write takes effect after the reset.
- R9: Status bits 4..7 latch pulses on rx_err_i[0..3] (overrun, parity, framing, received break) and clear only on misc field 4. A pulse in the same cycle as the clear wins.
- R10: A brk_change_i pulse sets interrupt status bit 2, and misc field 5 clears it. A pulse in the same cycle as the clear wins.
- R11: Misc field 6 raises tx_break_o and misc field 7 lowers it.
- R12: Interrupt status bit 0 equals status bit 2. Bit 1 equals status bit 1 when mode register 1 bit 6 is set, and status bit 0 otherwise. Bits 3..7 read 0.
- R13: irq_o is high exactly when the AND of interrupt status and interrupt mask is nonzero.
- R14: A transmit buffer write in the same cycle as a completed handshake sends the old byte and holds the new one, leaving transmitter-empty clear and tx_valid_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Register access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 6 | Byte offset inside the 64-byte window |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of a read access |
| tx_valid_o | output | 1 | Holding buffer offers a byte to the serializer |
| tx_ready_i | input | 1 | Serializer takes the offered byte |
| tx_data_o | output | 8 | Byte offered to the serializer |
| rx_avail_i | input | 1 | Receive queue holds at least one byte |
| rx_full_i | input | 1 | Receive queue is full |
| rx_err_i | input | 4 | Error pulses: overrun, parity, framing, received break |
| brk_change_i | input | 1 | Pulse on a change of line-break state |
| rx_enable_o | output | 1 | Receiver enable |
| rx_flush_o | output | 1 | One-cycle receiver reset pulse |
| tx_break_o | output | 1 | Request to hold the line in break |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle. A processor reload of the transmit buffer can coincide with the serializer taking the previous byte. A command's clear action can coincide with the event it clears: an error pulse or a break-change pulse. The bench drives both sides on the same clock edge. It then judges the outcome through tx_valid_o, tx_data_o and the status and interrupt status read-backs. The old byte must be gone, the new byte held and transmitter-empty still clear, and the fresh event must survive its clear. A single command that resets and re-enables a direction is judged the same way.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

  localparam int DATA_W = 8;
  localparam int WIN_W  = 6;
  localparam int ERR_N  = 4;

  localparam logic [WIN_W-1:0] OFF_MODE  = 6'h00;
  localparam logic [WIN_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [WIN_W-1:0] OFF_CMD   = 6'h08;
  localparam logic [WIN_W-1:0] OFF_TXB   = 6'h0C;
  localparam logic [WIN_W-1:0] OFF_MASK  = 6'h10;
  localparam logic [WIN_W-1:0] OFF_ISTAT = 6'h14;

  // status and interrupt status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;
  localparam int ST_ERR0  = 4;
  localparam int IS_TX    = 0;
  localparam int IS_RX    = 1;
  localparam int IS_DBRK  = 2;
  localparam int MODE_RXSEL = 6;

  typedef enum logic [2:0] {
    MISC_NOP      = 3'd0,
    MISC_PTR_RST  = 3'd1,
    MISC_RX_RST   = 3'd2,
    MISC_TX_RST   = 3'd3,
    MISC_ERR_RST  = 3'd4,
    MISC_DBRK_CLR = 3'd5,
    MISC_BRK_ON   = 3'd6,
    MISC_BRK_OFF  = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_ON   = 2'd1,
    EN_OFF  = 2'd2,
    EN_RSVD = 2'd3
  } en_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic dbrk_clr;
    logic brk_on;
    logic brk_off;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;

  typedef struct packed {
    logic mode;
    logic stat;
    logic mask;
    logic istat;
  } rd_sel_t;

  typedef struct packed {
    logic mode;
    logic cmd;
    logic txb;
    logic mask;
  } wr_sel_t;

endpackage

// File: rtl/uart_regctl_rstsync.sv
module uart_regctl_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_n;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/uart_regctl_decode.sv
module uart_regctl_decode
  import uart_regctl_pkg::*;
(
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [WIN_W-1:0] addr_i,
  output rd_sel_t          rd_sel_o,
  output wr_sel_t          wr_sel_o
);
  logic rd_go;
  logic wr_go;

  always_comb begin
    rd_go    = valid_i & ~write_i;
    wr_go    = valid_i &  write_i;
    rd_sel_o = '0;
    wr_sel_o = '0;
    case (addr_i)
      OFF_MODE: begin
        rd_sel_o.mode = rd_go;
        wr_sel_o.mode = wr_go;
      end
      OFF_STAT:  rd_sel_o.stat  = rd_go;
      OFF_CMD:   wr_sel_o.cmd   = wr_go;
      OFF_TXB:   wr_sel_o.txb   = wr_go;
      OFF_MASK: begin
        rd_sel_o.mask = rd_go;
        wr_sel_o.mask = wr_go;
      end
      OFF_ISTAT: rd_sel_o.istat = rd_go;
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_regctl_cmd.sv
module uart_regctl_cmd
  import uart_regctl_pkg::*;
(
  input  logic     we_i,
  input  logic [6:0] cmd_i,
  output cmd_act_t act_o
);
  misc_e misc;
  en_e   txf;
  en_e   rxf;

  always_comb begin
    misc  = misc_e'(cmd_i[6:4]);
    txf   = en_e'(cmd_i[3:2]);
    rxf   = en_e'(cmd_i[1:0]);
    act_o = '0;
    if (we_i) begin
      case (misc)
        MISC_PTR_RST:  act_o.ptr_rst  = 1'b1;
        MISC_RX_RST:   act_o.rx_rst   = 1'b1;
        MISC_TX_RST:   act_o.tx_rst   = 1'b1;
        MISC_ERR_RST:  act_o.err_rst  = 1'b1;
        MISC_DBRK_CLR: act_o.dbrk_clr = 1'b1;
        MISC_BRK_ON:   act_o.brk_on   = 1'b1;
        MISC_BRK_OFF:  act_o.brk_off  = 1'b1;
        default: ;
      endcase
      act_o.tx_on  = (txf == EN_ON);
      act_o.tx_off = (txf == EN_OFF);
      act_o.rx_on  = (rxf == EN_ON);
      act_o.rx_off = (rxf == EN_OFF);
    end
  end
endmodule

// File: rtl/uart_regctl_txbuf.sv
module uart_regctl_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          en_on_i,
  input  logic          en_off_i,
  input  logic          flush_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          en_o
);
  logic          en_q, en_n;
  logic          empty_q, empty_n;
  logic [DW-1:0] data_q;
  logic          take;

  always_comb begin
    take    = en_q & ~empty_q & ready_i;
    empty_n = empty_q;
    if (take)    empty_n = 1'b1;
    if (load_i)  empty_n = 1'b0;
    if (flush_i) empty_n = 1'b1;
    en_n = en_q;
    if (flush_i)  en_n = 1'b0;
    if (en_on_i)  en_n = 1'b1;
    if (en_off_i) en_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      en_q    <= en_n;
      empty_q <= empty_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (load_i) data_q <= load_data_i;
  end

  assign valid_o = en_q & ~empty_q;
  assign data_o  = data_q;
  assign empty_o = empty_q;
  assign en_o    = en_q;
endmodule

// File: rtl/uart_regctl_irq.sv
module uart_regctl_irq
  import uart_regctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txrdy_i,
  input  logic              rxrdy_i,
  input  logic              full_i,
  input  logic              rx_on_full_i,
  input  logic              dbrk_set_i,
  input  logic              dbrk_clr_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  output logic [DATA_W-1:0] isr_o,
  output logic [DATA_W-1:0] imr_o,
  output logic              irq_o
);
  logic              dbrk_q, dbrk_n;
  logic [DATA_W-1:0] imr_q;

  always_comb begin
    dbrk_n = dbrk_q;
    if (dbrk_clr_i) dbrk_n = 1'b0;
    if (dbrk_set_i) dbrk_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbrk_q <= 1'b0;
    else         dbrk_q <= dbrk_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        imr_q <= '0;
    else if (mask_we_i) imr_q <= mask_wdata_i;
  end

  always_comb begin
    isr_o          = '0;
    isr_o[IS_TX]   = txrdy_i;
    isr_o[IS_RX]   = rx_on_full_i ? full_i : rxrdy_i;
    isr_o[IS_DBRK] = dbrk_q;
  end

  assign imr_o = imr_q;
  assign irq_o = |(isr_o & imr_q);
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
  import uart_regctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [WIN_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_avail_i,
  input  logic              rx_full_i,
  input  logic [ERR_N-1:0]  rx_err_i,
  input  logic              brk_change_i,
  output logic              rx_enable_o,
  output logic              rx_flush_o,
  output logic              tx_break_o,
  output logic              irq_o
);
  logic              rst_sync_n;
  rd_sel_t           rd_sel;
  wr_sel_t           wr_sel;
  cmd_act_t          act;
  logic              tx_empty;
  logic              tx_en;
  logic [DATA_W-1:0] isr;
  logic [DATA_W-1:0] imr_q;
  logic [DATA_W-1:0] status;

  logic              mr_ptr_q, mr_ptr_n;
  logic [DATA_W-1:0] mr1_q, mr2_q;
  logic              rx_en_q, rx_en_n;
  logic              flush_q, flush_n;
  logic              brk_q, brk_n;
  logic [ERR_N-1:0]  err_q;

  uart_regctl_rstsync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  uart_regctl_decode u_dec (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i),
    .rd_sel_o(rd_sel), .wr_sel_o(wr_sel)
  );

  uart_regctl_cmd u_cmd (
    .we_i(wr_sel.cmd), .cmd_i(bus_wdata_i[6:0]), .act_o(act)
  );

  uart_regctl_txbuf #(.DW(DATA_W)) u_txb (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .load_i(wr_sel.txb), .load_data_i(bus_wdata_i),
    .en_on_i(act.tx_on), .en_off_i(act.tx_off), .flush_i(act.tx_rst),
    .ready_i(tx_ready_i), .valid_o(tx_valid_o), .data_o(tx_data_o),
    .empty_o(tx_empty), .en_o(tx_en)
  );

  uart_regctl_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .txrdy_i(status[ST_TXRDY]), .rxrdy_i(status[ST_RXRDY]),
    .full_i(status[ST_FULL]), .rx_on_full_i(mr1_q[MODE_RXSEL]),
    .dbrk_set_i(brk_change_i), .dbrk_clr_i(act.dbrk_clr),
    .mask_we_i(wr_sel.mask), .mask_wdata_i(bus_wdata_i),
    .isr_o(isr), .imr_o(imr_q), .irq_o(irq_o)
  );

  // mode register pointer and storage
  always_comb begin
    mr_ptr_n = mr_ptr_q;
    if (rd_sel.mode || wr_sel.mode) mr_ptr_n = 1'b1;
    if (act.ptr_rst)                mr_ptr_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) mr_ptr_q <= 1'b0;
    else             mr_ptr_q <= mr_ptr_n;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)                  mr1_q <= '0;
    else if (wr_sel.mode && !mr_ptr_q) mr1_q <= bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)                 mr2_q <= '0;
    else if (wr_sel.mode && mr_ptr_q) mr2_q <= bus_wdata_i;
  end

  // receiver control and line break
  always_comb begin
    rx_en_n = rx_en_q;
    if (act.rx_rst) rx_en_n = 1'b0;
    if (act.rx_on)  rx_en_n = 1'b1;
    if (act.rx_off) rx_en_n = 1'b0;
    flush_n = act.rx_rst;
    brk_n   = brk_q;
    if (act.brk_on)  brk_n = 1'b1;
    if (act.brk_off) brk_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_en_q <= 1'b0;
      flush_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      rx_en_q <= rx_en_n;
      flush_q <= flush_n;
      brk_q   <= brk_n;
    end
  end

  // sticky receive error flags, one cell per source
  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    logic cell_n;
    always_comb begin
      cell_n = err_q[g];
      if (act.err_rst) cell_n = 1'b0;
      if (rx_err_i[g]) cell_n = 1'b1;
    end
    always_ff @(posedge clk_i or negedge rst_sync_n) begin
      if (!rst_sync_n) err_q[g] <= 1'b0;
      else             err_q[g] <= cell_n;
    end
  end

  // status byte and read mux
  always_comb begin
    status                          = '0;
    status[ST_RXRDY]                = rx_avail_i;
    status[ST_FULL]                 = rx_full_i;
    status[ST_TXRDY]                = tx_en & tx_empty;
    status[ST_TXEMP]                = tx_empty;
    status[ST_ERR0 +: ERR_N]        = err_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_sel.mode)  bus_rdata_o = mr_ptr_q ? mr2_q : mr1_q;
    if (rd_sel.stat)  bus_rdata_o = status;
    if (rd_sel.mask)  bus_rdata_o = imr_q;
    if (rd_sel.istat) bus_rdata_o = isr;
  end

  assign rx_enable_o = rx_en_q;
  assign rx_flush_o  = flush_q;
  assign tx_break_o  = brk_q;
endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk
  import uart_regctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [WIN_W-1:0]  bus_addr_i,
  input logic [2:0]        misc_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_empty,
  input logic              mr_ptr_q,
  input logic [ERR_N-1:0]  err_q,
  input logic [DATA_W-1:0] imr_q,
  input logic              irq_o,
  input logic              rx_flush_o
);
  logic txb_wr;
  logic cmd_wr;
  assign txb_wr = bus_valid_i && bus_write_i && (bus_addr_i == OFF_TXB);
  assign cmd_wr = bus_valid_i && bus_write_i && (bus_addr_i == OFF_CMD);

  // R5
  txb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    txb_wr |=> !tx_empty);

  // R5
  txb_handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && !txb_wr) |=> tx_empty);

  // R5
  txb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && !bus_valid_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R14
  txb_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && txb_wr) |=> (tx_valid_o && !tx_empty));

  // R2
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mr_ptr_q && !(cmd_wr && misc_i == 3'd1)) |=> mr_ptr_q);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(cmd_wr && misc_i == 3'd4) |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R13
  mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (imr_q == '0) |-> !irq_o);

  // R8
  flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_flush_o |-> $past(cmd_wr && misc_i == 3'd2));
endmodule

bind uart_regctl uart_regctl_chk chk_i (
  .clk_i(clk_i), .rst_n(rst_sync_n),
  .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
  .bus_addr_i(bus_addr_i), .misc_i(bus_wdata_i[6:4]),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .tx_empty(tx_empty), .mr_ptr_q(mr_ptr_q), .err_q(err_q),
  .imr_q(imr_q), .irq_o(irq_o), .rx_flush_o(rx_flush_o)
);

// File: tb/uart_regctl_tb_top.sv
module uart_regctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bv, bw;
  logic [5:0] ba;
  logic [7:0] bwd, brd;
  logic       txv, txr;
  logic [7:0] txd;
  logic       ravail, rfull;
  logic [3:0] rerr;
  logic       bchg;
  logic       rxen, rxfl, txbrk, irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regctl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba),
    .bus_wdata_i(bwd), .bus_rdata_o(brd),
    .tx_valid_o(txv), .tx_ready_i(txr), .tx_data_o(txd),
    .rx_avail_i(ravail), .rx_full_i(rfull), .rx_err_i(rerr),
    .brk_change_i(bchg), .rx_enable_o(rxen), .rx_flush_o(rxfl),
    .tx_break_o(txbrk), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bv = 1'b1; bw = 1'b1; ba = a; bwd = d;
    @(negedge clk);
    bv = 1'b0; bw = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bv = 1'b1; bw = 1'b0; ba = a;
    #1 d = brd;
    @(negedge clk);
    bv = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {24'd0, v}, {24'd0, exp});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] isr_exp;
    bv = 0; bw = 0; ba = 0; bwd = 0; txr = 0;
    ravail = 0; rfull = 0; rerr = 0; bchg = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rdchk("R1 status", 6'h04, 8'h08);
    rdchk("R1 istat", 6'h14, 8'h00);
    rdchk("R1 mask", 6'h10, 8'h00);
    chk("R1 outputs", {txv, rxen, rxfl, txbrk, irq}, 5'b0);
    rdchk("R1 mode1", 6'h00, 8'h00);
    rdchk("R1 mode2", 6'h00, 8'h00);

    // R2 pointer
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h11);
    wr(6'h00, 8'h22);
    wr(6'h00, 8'h33);
    wr(6'h08, 8'h10);
    rdchk("R2 mode1 after ptr reset", 6'h00, 8'h11);
    rdchk("R2 mode2 after advance", 6'h00, 8'h33);
    rdchk("R2 pointer sticky", 6'h00, 8'h33);

    // R4 writes to read-only and unmapped offsets
    wr(6'h10, 8'hA5);
    for (int o = 0; o < 64; o++) begin
      if (o != 6'h00 && o != 6'h08 && o != 6'h0C && o != 6'h10)
        wr(6'(o), 8'hFF);
    end
    chk("R4 outputs untouched", {txv, rxen, rxfl, txbrk}, 4'b0);

    // R3 read sweep over the whole window
    for (int o = 0; o < 64; o++) begin
      logic [7:0] e;
      case (o)
        6'h00:   e = 8'h33;
        6'h04:   e = 8'h08;
        6'h10:   e = 8'hA5;
        6'h14:   e = 8'h00;
        default: e = 8'h00;
      endcase
      rd(6'(o), v);
      chk($sformatf("R3 R4 read offset 0x%0h", o), {24'd0, v}, {24'd0, e});
    end
    wr(6'h10, 8'h00);

    // R7 enable field sweep from both starting states
    for (int s = 0; s < 2; s++)
      for (int tf = 0; tf < 4; tf++)
        for (int rf = 0; rf < 4; rf++) begin
          logic te, re;
          wr(6'h08, s[0] ? 8'h05 : 8'h0A);
          wr(6'h08, 8'((tf << 2) | rf));
          te = (tf == 1) ? 1'b1 : (tf == 2) ? 1'b0 : s[0];
          re = (rf == 1) ? 1'b1 : (rf == 2) ? 1'b0 : s[0];
          chk($sformatf("R7 rx field s=%0d t=%0d r=%0d", s, tf, rf), {31'd0, rxen}, {31'd0, re});
          rd(6'h04, v);
          chk($sformatf("R7 R6 txrdy s=%0d t=%0d r=%0d", s, tf, rf), {31'd0, v[2]}, {31'd0, te});
        end

    // R5 R6 transmit holding buffer
    wr(6'h08, 8'h0A);
    wr(6'h08, 8'h04);
    rdchk("R6 enabled empty", 6'h04, 8'h0C);
    wr(6'h0C, 8'hA7);
    rdchk("R5 R6 loaded", 6'h04, 8'h00);
    chk("R5 valid data", {23'd0, txv, txd}, {23'd0, 1'b1, 8'hA7});
    repeat (3) @(negedge clk);
    chk("R5 held", {23'd0, txv, txd}, {23'd0, 1'b1, 8'hA7});
    txr = 1'b1;
    @(negedge clk);
    txr = 1'b0;
    chk("R5 taken", {31'd0, txv}, 32'd0);
    rdchk("R5 empty again", 6'h04, 8'h0C);
    wr(6'h08, 8'h08);
    txr = 1'b1;
    wr(6'h0C, 8'h3C);
    chk("R5 disabled holds", {31'd0, txv}, 32'd0);
    txr = 1'b0;
    rdchk("R5 R6 disabled not empty", 6'h04, 8'h00);
    wr(6'h08, 8'h04);
    chk("R5 enable offers", {23'd0, txv, txd}, {23'd0, 1'b1, 8'h3C});

    // R14 reload on the handshake cycle
    @(negedge clk);
    txr = 1'b1; bv = 1'b1; bw = 1'b1; ba = 6'h0C; bwd = 8'h5E;
    @(negedge clk);
    txr = 1'b0; bv = 1'b0; bw = 1'b0;
    chk("R14 new byte held", {23'd0, txv, txd}, {23'd0, 1'b1, 8'h5E});
    rdchk("R14 empty clear", 6'h04, 8'h00);

    // R8 transmitter reset, alone and with enable
    wr(6'h08, 8'h30);
    chk("R8 tx reset drops valid", {31'd0, txv}, 32'd0);
    rdchk("R8 tx reset status", 6'h04, 8'h08);
    wr(6'h0C, 8'h77);
    wr(6'h08, 8'h34);
    rdchk("R8 reset then enable", 6'h04, 8'h0C);
    // R8 receiver reset
    wr(6'h08, 8'h01);
    wr(6'h08, 8'h20);
    chk("R8 rx reset pulse", {30'd0, rxfl, rxen}, {30'd0, 2'b10});
    @(negedge clk);
    chk("R8 rx pulse one cycle", {31'd0, rxfl}, 32'd0);
    wr(6'h08, 8'h21);
    chk("R8 rx reset then enable", {30'd0, rxfl, rxen}, {30'd0, 2'b11});
    wr(6'h08, 8'h08);

    // R9 sticky errors
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rerr = 4'(1 << k);
      @(negedge clk); rerr = 4'd0;
      rd(6'h04, v);
      chk($sformatf("R9 error bit %0d", k), {28'd0, v[7:4]}, {28'd0, 4'((2 << k) - 1)});
    end
    wr(6'h08, 8'h40);
    rdchk("R9 cleared", 6'h04, 8'h08);
    @(negedge clk);
    rerr = 4'b0010; bv = 1'b1; bw = 1'b1; ba = 6'h08; bwd = 8'h40;
    @(negedge clk);
    rerr = 4'd0; bv = 1'b0; bw = 1'b0;
    rdchk("R9 set beats clear", 6'h04, 8'h28);
    wr(6'h08, 8'h40);

    // R10 delta break
    @(negedge clk); bchg = 1'b1;
    @(negedge clk); bchg = 1'b0;
    rdchk("R10 set", 6'h14, 8'h04);
    wr(6'h08, 8'h50);
    rdchk("R10 cleared", 6'h14, 8'h00);
    @(negedge clk);
    bchg = 1'b1; bv = 1'b1; bw = 1'b1; ba = 6'h08; bwd = 8'h50;
    @(negedge clk);
    bchg = 1'b0; bv = 1'b0; bw = 1'b0;
    rdchk("R10 set beats clear", 6'h14, 8'h04);
    wr(6'h08, 8'h50);

    // R11 break control
    wr(6'h08, 8'h60);
    chk("R11 break on", {31'd0, txbrk}, 32'd1);
    wr(6'h08, 8'h70);
    chk("R11 break off", {31'd0, txbrk}, 32'd0);

    // R12 R13 interrupt source and mask sweep
    wr(6'h08, 8'h30);
    for (int st = 0; st < 16; st++) begin
      logic m, a, f, t;
      {m, a, f, t} = 4'(st);
      wr(6'h08, 8'h10);
      wr(6'h00, m ? 8'h40 : 8'h00);
      @(negedge clk);
      ravail = a; rfull = f;
      wr(6'h08, t ? 8'h04 : 8'h08);
      isr_exp = {5'd0, 1'b0, (m ? f : a), t};
      rd(6'h04, v);
      chk($sformatf("R6 status low bits st=%0d", st), {29'd0, v[2:0]}, {29'd0, t, f, a});
      rdchk($sformatf("R12 istat st=%0d", st), 6'h14, isr_exp);
      for (int mk = 0; mk < 256; mk++) begin
        wr(6'h10, 8'(mk));
        chk($sformatf("R13 irq st=%0d mask=0x%0h", st, mk), {31'd0, irq},
            {31'd0, |(isr_exp & 8'(mk))});
      end
    end
    ravail = 0; rfull = 0;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule